// File: doc/BRIEF.md
# Low-Power Standby Controller

This block decides when a microcontroller-style system may drop into a deep standby state, and how it leaves that state again. Software requests standby by writing a control register whose request bit is active-low: a write of 0 asks for standby. The request is honoured only when the system clock runs from the main oscillator or the PLL, and only when no interrupt is waiting. When the request is accepted, the CPU and peripheral clock enables fall one cycle later. The always-on domain keeps running throughout: oscillator, subclock, timebase counter, watch counter and low-voltage detector.

A second register bit chooses what the pins do in standby: hold their last driven value, or go high-impedance. No state is cleared on entry. A pending interrupt wakes the system: the clocks return, the clock mode saved at entry is presented again, and the CPU sees a one-cycle wake pulse. A reset request leaves standby by a different path. It first forces main clock mode for one cycle and then raises a one-cycle reset-sequence indication. A standby request refused because of a pending interrupt produces one of two one-cycle outcome pulses: continue with the next instruction, or branch to the handler. Which one depends on whether interrupts are being accepted.

Top module: `standby_ctrl`

## Requirements
- R1: A write with bit 7 of `wr_data_i` equal to 0, while running, with `ck_mode_i` at main (2'b00) or PLL (2'b01), no interrupt pending and no reset request, sets `stby_o` on the following cycle.
- R2: While `stby_o` is 1, `cpu_clk_en_o` and `per_clk_en_o` are 0; at all other times both are 1. Every bit of `aon_en_o` is always 1.
- R3: A standby request while `ck_mode_i` is subclock (2'b10) or the reserved code (2'b11) is ignored: `stby_o` stays 0.
- R4: A standby request while `irq_pend_i` is 1 is ignored: `stby_o` stays 0 and bit 7 of `rd_data_o` stays 1.
- R5: A request refused by a pending interrupt produces, on the next cycle, a one-cycle `blk_br_o` pulse if `irq_acc_i` is 1, or else a one-cycle `blk_cont_o` pulse.
- R6: Bit 4 of the register selects the pin state in standby (1 = high impedance, 0 = hold). `pin_hiz_o` equals that bit in exactly the cycles where the clocks are gated, and is 0 otherwise.
- R7: `irq_pend_i` in standby, with no reset request, ends standby on the next cycle. In that cycle the clocks are enabled, `wake_o` is 1 for exactly that one cycle, and `ck_sel_o` follows `ck_mode_i` again. While in standby, `ck_sel_o` shows the mode captured at entry.
- R8: `rst_req_i`, in standby or while running, leads on the next cycle to one cycle with the clocks enabled and `ck_sel_o` = main (2'b00). In the cycle after that, `rst_seq_o` is 1 for exactly one cycle and `ck_sel_o` is still main. A reset request takes priority over an interrupt.
- R9: `rd_data_o` bit 7 reads 0 only while in standby and 1 otherwise. Bit 4 reads the pin-select value last written outside standby; writes during standby change nothing. All other bits read 0. After reset the pin select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | DW | Write data (bit 7 request, active low; bit 4 pin select) |
| rd_data_o | output | DW | Control register read value |
| ck_mode_i | input | 2 | Current clock mode (00 main, 01 PLL, 10 sub, 11 reserved) |
| irq_pend_i | input | 1 | An interrupt request is pending |
| irq_acc_i | input | 1 | The CPU currently accepts interrupts |
| rst_req_i | input | 1 | Reset factor request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| aon_en_o | output | AON_N | Oscillator, subclock, timebase, watch, LVD enables |
| pin_hiz_o | output | 1 | Force pins to high impedance |
| wake_o | output | 1 | One-cycle wake pulse to CPU |
| ck_sel_o | output | 2 | Clock mode select |
| rst_seq_o | output | 1 | Start of reset sequence |
| stby_o | output | 1 | Controller is in standby |
| blk_cont_o | output | 1 | Refused request: continue with next instruction |
| blk_br_o | output | 1 | Refused request: branch to interrupt handler |

## Verification
Several properties are checked on every cycle:
- a qualifying request always lands in standby;
- a request made under a pending interrupt never does;
- the wake pulse never lasts two cycles;
- outcome pulses appear only while running;
- high impedance occurs only in standby;
- the reset-sequence pulse always comes with main mode selected;
- the pin select does not change in standby.

Other behaviour only shows up in the bench scenarios, where a behavioural model is compared against every output on every clock:
- that the saved PLL mode is presented during standby;
- that hold versus high impedance follows the written bit;
- that subclock and reserved modes refuse entry;
- that the continue and branch outcomes follow `irq_acc_i`;
- that a reset request beats a simultaneous interrupt.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int DW_DEF    = 8;
    localparam int REQ_BIT   = 7;
    localparam int PSEL_BIT  = 4;
    localparam int AON_N_DEF = 5;

    typedef enum logic [1:0] {
        CK_MAIN = 2'b00,
        CK_PLL  = 2'b01,
        CK_SUB  = 2'b10,
        CK_RSV  = 2'b11
    } ck_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_STBY = 2'b01,
        ST_RSTX = 2'b10,
        ST_RSEQ = 2'b11
    } stby_st_e;

    typedef struct packed {
        logic req;   // standby requested by this write
        logic psel;  // pin-select value carried by this write
    } wr_dec_t;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic hiz;
        logic rseq;
        logic stby;
    } gate_t;

    function automatic logic mode_ok(ck_mode_e m);
        return (m == CK_MAIN) || (m == CK_PLL);
    endfunction

endpackage

// File: rtl/stby_regif.sv
module stby_regif
    import stby_pkg::*;
#(
    parameter int DW     = DW_DEF,
    parameter int RQ_POS = REQ_BIT,
    parameter int PS_POS = PSEL_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          in_stby_i,
    output wr_dec_t       dec_o,
    output logic          psel_o,
    output logic [DW-1:0] rd_data_o
);

    logic psel_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i;

    // writes are only decoded while the CPU clock runs
    assign dec_o.req  = wr_en_i && !in_stby_i && !wr_data_i[RQ_POS];
    assign dec_o.psel = wr_data_i[PS_POS];

    always_ff @(posedge clk) begin
        if (rst) begin
            psel_q <= 1'b0;
        end else if (wr_en_i && !in_stby_i) begin
            psel_q <= wr_data_i[PS_POS];
        end
    end

    assign psel_o = psel_q;

    for (genvar b = 0; b < DW; b++) begin : g_rd
        if (b == RQ_POS) begin : g_req
            assign rd_data_o[b] = ~in_stby_i;
        end else if (b == PS_POS) begin : g_psel
            assign rd_data_o[b] = psel_q;
        end else begin : g_zero
            assign rd_data_o[b] = 1'b0;
        end
    end

    // R9: pin select frozen while in standby
    p_psel_hold_r9: assert property (@(posedge clk) disable iff (rst)
        in_stby_i |=> (psel_q == $past(psel_q)));

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_dec_t  dec_i,
    input  ck_mode_e ck_mode_i,
    input  logic     irq_pend_i,
    input  logic     irq_acc_i,
    input  logic     rst_req_i,
    output stby_st_e st_o,
    output ck_mode_e saved_o,
    output logic     wake_o,
    output logic     blk_cont_o,
    output logic     blk_br_o
);

    stby_st_e st_q, st_d;
    ck_mode_e saved_q;
    logic     wake_q, bc_q, bb_q;
    logic     refuse, enter, leave_irq;

    assign refuse    = (st_q == ST_RUN) && !rst_req_i && dec_i.req && irq_pend_i;
    assign enter     = (st_q == ST_RUN) && !rst_req_i && dec_i.req && !irq_pend_i
                       && mode_ok(ck_mode_i);
    assign leave_irq = (st_q == ST_STBY) && !rst_req_i && irq_pend_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (rst_req_i)  st_d = ST_RSTX;
                else if (enter) st_d = ST_STBY;
            end
            ST_STBY: begin
                if (rst_req_i)      st_d = ST_RSTX;
                else if (leave_irq) st_d = ST_RUN;
            end
            ST_RSTX: st_d = ST_RSEQ;
            ST_RSEQ: st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_RUN;
            saved_q <= CK_MAIN;
            wake_q  <= 1'b0;
            bc_q    <= 1'b0;
            bb_q    <= 1'b0;
        end else begin
            st_q   <= st_d;
            wake_q <= leave_irq;
            bc_q   <= refuse && !irq_acc_i;
            bb_q   <= refuse && irq_acc_i;
            if (enter) saved_q <= ck_mode_i;
        end
    end

    assign st_o       = st_q;
    assign saved_o    = saved_q;
    assign wake_o     = wake_q;
    assign blk_cont_o = bc_q;
    assign blk_br_o   = bb_q;

    // R1: a qualifying request always lands in standby
    p_entry_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !rst_req_i && dec_i.req && !irq_pend_i && mode_ok(ck_mode_i))
        |=> (st_q == ST_STBY));

    // R4: a request under a pending interrupt never enters standby
    p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && dec_i.req && irq_pend_i) |=> (st_q != ST_STBY));

    // R7: wake lasts one cycle
    p_wake_once_r7: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q);

    // R5: outcome pulses only while running, never both
    p_blk_run_r5: assert property (@(posedge clk) disable iff (rst)
        (bc_q || bb_q) |-> (st_q == ST_RUN && !(bc_q && bb_q)));

endmodule

// File: rtl/stby_gate.sv
module stby_gate
    import stby_pkg::*;
#(
    parameter int AON_N = AON_N_DEF
) (
    input  stby_st_e         st_i,
    input  logic             psel_i,
    input  ck_mode_e         saved_i,
    input  ck_mode_e         ck_mode_i,
    output gate_t            gate_o,
    output logic [AON_N-1:0] aon_o,
    output ck_mode_e         ck_sel_o
);

    always_comb begin
        gate_o        = '0;
        gate_o.stby   = (st_i == ST_STBY);
        gate_o.cpu_en = !gate_o.stby;
        gate_o.per_en = !gate_o.stby;
        gate_o.hiz    = gate_o.stby && psel_i;
        gate_o.rseq   = (st_i == ST_RSEQ);
    end

    always_comb begin
        unique case (st_i)
            ST_RUN:  ck_sel_o = ck_mode_i;
            ST_STBY: ck_sel_o = saved_i;
            default: ck_sel_o = CK_MAIN;
        endcase
    end

    assign aon_o = '1;

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int DW     = DW_DEF,
    parameter int AON_N  = AON_N_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [DW-1:0]    rd_data_o,
    input  logic [1:0]       ck_mode_i,
    input  logic             irq_pend_i,
    input  logic             irq_acc_i,
    input  logic             rst_req_i,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic [AON_N-1:0] aon_en_o,
    output logic             pin_hiz_o,
    output logic             wake_o,
    output logic [1:0]       ck_sel_o,
    output logic             rst_seq_o,
    output logic             stby_o,
    output logic             blk_cont_o,
    output logic             blk_br_o
);

    wr_dec_t  dec;
    logic     psel;
    stby_st_e st;
    ck_mode_e saved, ck_sel;
    gate_t    gate;
    ck_mode_e mode_in;

    assign mode_in = ck_mode_e'(ck_mode_i);

    stby_regif #(.DW(DW), .RQ_POS(REQ_BIT), .PS_POS(PSEL_BIT)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .in_stby_i (gate.stby),
        .dec_o     (dec),
        .psel_o    (psel),
        .rd_data_o (rd_data_o)
    );

    stby_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dec_i      (dec),
        .ck_mode_i  (mode_in),
        .irq_pend_i (irq_pend_i),
        .irq_acc_i  (irq_acc_i),
        .rst_req_i  (rst_req_i),
        .st_o       (st),
        .saved_o    (saved),
        .wake_o     (wake_o),
        .blk_cont_o (blk_cont_o),
        .blk_br_o   (blk_br_o)
    );

    stby_gate #(.AON_N(AON_N)) u_gate (
        .st_i      (st),
        .psel_i    (psel),
        .saved_i   (saved),
        .ck_mode_i (mode_in),
        .gate_o    (gate),
        .aon_o     (aon_en_o),
        .ck_sel_o  (ck_sel)
    );

    assign cpu_clk_en_o = gate.cpu_en;
    assign per_clk_en_o = gate.per_en;
    assign pin_hiz_o    = gate.hiz;
    assign rst_seq_o    = gate.rseq;
    assign stby_o       = gate.stby;
    assign ck_sel_o     = ck_sel;

    // R6: high impedance only with the clocks gated
    p_hiz_gated_r6: assert property (@(posedge clk) disable iff (rst)
        pin_hiz_o |-> (stby_o && !cpu_clk_en_o));

    // R8: reset sequence follows a cycle of forced main mode
    p_rst_main_r8: assert property (@(posedge clk) disable iff (rst)
        rst_seq_o |-> (ck_sel_o == 2'b00 && $past(ck_sel_o) == 2'b00 && !$past(rst_seq_o)));

    // R2: gating tracks standby
    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        stby_o |-> (!cpu_clk_en_o && !per_clk_en_o));

endmodule

// File: tb/tb_standby_ctrl.sv
module tb_standby_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h80;
    logic [7:0] rd_data;
    logic [1:0] ck_mode = 2'b00;
    logic       irq_pend = 1'b0, irq_acc = 1'b0, rst_req = 1'b0;
    logic       cpu_en, per_en, hiz, wake, rseq, stby, bc, bb;
    logic [4:0] aon;
    logic [1:0] ck_sel;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    standby_ctrl dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .ck_mode_i(ck_mode), .irq_pend_i(irq_pend), .irq_acc_i(irq_acc), .rst_req_i(rst_req),
        .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .aon_en_o(aon), .pin_hiz_o(hiz),
        .wake_o(wake), .ck_sel_o(ck_sel), .rst_seq_o(rseq), .stby_o(stby),
        .blk_cont_o(bc), .blk_br_o(bb)
    );

    // behavioural reference: 0 run, 1 standby, 2 forced-main, 3 reset-seq
    int m_st = 0, m_psel = 0, m_saved = 0, m_wake = 0, m_bc = 0, m_bb = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_psel = 0; m_saved = 0; m_wake = 0; m_bc = 0; m_bb = 0;
        end else begin
            int req;
            int nxt;
            req = (wr_en && !wr_data[7] && m_st != 1) ? 1 : 0;
            m_wake = 0; m_bc = 0; m_bb = 0;
            nxt = m_st;
            if (m_st == 2) nxt = 3;
            else if (m_st == 3) nxt = 0;
            else if (rst_req) nxt = 2;
            else if (m_st == 1) begin
                if (irq_pend) begin nxt = 0; m_wake = 1; end
            end else if (req == 1) begin
                if (irq_pend) begin
                    if (irq_acc) m_bb = 1; else m_bc = 1;
                end else if (ck_mode < 2) begin
                    nxt = 1; m_saved = ck_mode;
                end
            end
            if (wr_en && m_st != 1) m_psel = wr_data[4];
            m_st = nxt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic cmp_all();
        int e_sel;
        e_sel = (m_st == 0) ? int'(ck_mode) : (m_st == 1) ? m_saved : 0;
        chk("R1 stby_o", stby, m_st == 1);
        chk("R2 cpu_clk_en_o", cpu_en, m_st != 1);
        chk("R2 per_clk_en_o", per_en, m_st != 1);
        chk("R2 aon_en_o", aon, 31);
        chk("R6 pin_hiz_o", hiz, (m_st == 1) && (m_psel == 1));
        chk("R7 wake_o", wake, m_wake);
        chk("R7/R8 ck_sel_o", ck_sel, e_sel);
        chk("R8 rst_seq_o", rseq, m_st == 3);
        chk("R5 blk_cont_o", bc, m_bc);
        chk("R5 blk_br_o", bb, m_bb);
        chk("R9 rd_data_o", rd_data, ((m_st != 1) ? 128 : 0) + m_psel * 16);
    endtask

    task automatic cyc(input bit w, input logic [7:0] d, input logic [1:0] m,
                       input bit ip, input bit ia, input bit rr);
        wr_en = w; wr_data = d; ck_mode = m; irq_pend = ip; irq_acc = ia; rst_req = rr;
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle(input int n, input logic [1:0] m);
        for (int i = 0; i < n; i++) cyc(0, 8'h80, m, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_all();
        chk("R9 reset read", rd_data, 8'h80);
        idle(2, 2'b00);

        // R1/R6: enter from main mode, hold pins
        cyc(1, 8'h00, 2'b00, 0, 0, 0);
        chk("R1 entered", stby, 1);
        idle(3, 2'b00);
        cyc(1, 8'h10, 2'b00, 0, 0, 0);           // write in standby: R9 ignored
        cyc(0, 8'h80, 2'b00, 1, 0, 0);           // R7 irq exit
        chk("R7 wake", wake, 1);
        idle(2, 2'b00);
        chk("R9 psel untouched", rd_data, 8'h80);

        // R6/R7: PLL mode, high impedance, saved mode shown while input changes
        cyc(1, 8'h10, 2'b01, 0, 0, 0);
        chk("R6 hiz", hiz, 1);
        idle(2, 2'b00);
        chk("R7 saved mode", ck_sel, 2'b01);
        cyc(0, 8'h80, 2'b01, 1, 1, 0);
        idle(2, 2'b01);

        // R3: subclock and reserved modes refuse
        cyc(1, 8'h00, 2'b10, 0, 0, 0);
        chk("R3 sub refused", stby, 0);
        cyc(1, 8'h00, 2'b11, 0, 0, 0);
        chk("R3 rsv refused", stby, 0);

        // R4/R5: pending interrupt refuses; outcome follows accept enable
        cyc(1, 8'h00, 2'b00, 1, 0, 0);
        chk("R4 refused", stby, 0);
        chk("R4 req bit", rd_data[7], 1);
        chk("R5 continue", bc, 1);
        cyc(1, 8'h00, 2'b01, 1, 1, 0);
        chk("R5 branch", bb, 1);
        idle(2, 2'b00);

        // request bit 1 does not enter
        cyc(1, 8'h90, 2'b00, 0, 0, 0);
        chk("R1 no entry on 1", stby, 0);

        // R8: reset exit from standby, reset beats interrupt
        cyc(1, 8'h00, 2'b01, 0, 0, 0);
        idle(2, 2'b01);
        cyc(0, 8'h80, 2'b01, 1, 0, 1);
        chk("R8 forced main", ck_sel, 2'b00);
        cyc(0, 8'h80, 2'b01, 0, 0, 0);
        chk("R8 reset seq", rseq, 1);
        idle(3, 2'b01);

        // R8: reset request while running
        cyc(0, 8'h80, 2'b01, 0, 0, 1);
        idle(4, 2'b01);

        // back-to-back entries and exits
        for (int k = 0; k < 8; k++) begin
            cyc(1, (k[0] ? 8'h10 : 8'h00), k[1] ? 2'b01 : 2'b00, 0, 0, 0);
            idle(k % 3, 2'b00);
            cyc(0, 8'h80, 2'b00, 1, k[2], k == 5);
            idle(2, 2'b00);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule